// File: doc/BRIEF.md
# Credit-Based DMA Channel Flow Controller

This block is the flow-control engine of one DMA channel. The channel either fills a peripheral FIFO (transmit) or empties one (receive). That FIFO reports no full or empty status. The only thing it sends back is a single pulse for each word it takes out (transmit) or puts in (receive). The controller therefore keeps its own count of the words sitting in the FIFO. The count moves by the burst size for each burst it launches and by one for each peripheral pulse.

A burst is launched only when it fits. In transmit, the whole burst must fit into the free space. In receive, the whole burst must already be waiting in the FIFO. The memory side is a plain request/done handshake, and at most one burst is in flight at any time. Three settings are captured when the channel is switched on: the FIFO depth, the burst length and the direction. A bad setting leaves the channel parked in a fault state. Counting mistakes by the peripheral, in either direction, raise a sticky error flag.

The FSM has four states. CH_OFF is the disabled state: the count is held at zero and the settings follow the inputs. CH_ARMED waits until the count allows a burst. CH_BUSY is a burst in flight. CH_FAULT holds a rejected setting.

The transitions are:
- OFF→ARMED: enable with a valid setting.
- OFF→FAULT: enable with an invalid setting.
- ARMED→BUSY: the issue edge.
- BUSY→ARMED: done.
- ANY→OFF: enable low.

Top module: `dma_credit_flow`

## Requirements
- R1: After reset, `fill_level` is 0 and `burst_req`, `cfg_err` and `cnt_err` are all 0.
- R2: If `chan_en` rises while `cfg_burst_words` is 0 or is not smaller than `cfg_fifo_words`, the channel enters the fault state. In that state `cfg_err` is 1 and no request is made until `chan_en` is low.
- R3: Depth, burst length and direction are captured on the edge that enables the channel. Later changes to these inputs have no effect while the channel stays enabled.
- R4: Transmit (`dir_rx`=0). In the armed state, a burst is issued at a clock edge where count + burst ≤ depth. At that edge the count grows by the burst length, and `burst_req` is 1 from the following cycle.
- R5: Transmit. Each cycle with `per_evt`=1 while the channel is active lowers the count by one.
- R6: Receive (`dir_rx`=1). Each `per_evt` cycle raises the count by one. A burst is issued at an edge where count ≥ burst, and that edge lowers the count by the burst length.
- R7: `burst_req` stays 1 until a cycle with `burst_done`=1. After that cycle the channel spends at least one cycle armed before the next issue.
- R8: If an issue and a `per_evt` fall on the same edge, both changes are applied to the count.
- R9: Driving `chan_en` low clears the count, `burst_req`, `cfg_err` and `cnt_err` at the next edge.
- R10: An event that would take the count below zero sets `cnt_err`, and the count stays at 0.
- R11: An event that would take the count above the depth sets `cnt_err`, and the count stays at the depth.
- R12: `cnt_err` stays set while the channel remains enabled. The channel keeps working while the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| dir_rx | input | 1 | 0 = transmit (fill FIFO), 1 = receive (drain FIFO) |
| cfg_fifo_words | input | CNT_W | Peripheral FIFO depth in words |
| cfg_burst_words | input | CNT_W | Words moved per burst |
| per_evt | input | 1 | One word consumed (transmit) or produced (receive) by the peripheral |
| burst_done | input | 1 | Memory side has finished the outstanding burst |
| burst_req | output | 1 | A burst is outstanding |
| fill_level | output | CNT_W | Tracked FIFO occupancy in words |
| cfg_err | output | 1 | Channel held in fault because of a bad setting |
| cnt_err | output | 1 | Sticky under/overflow of the tracked count |

## Verification
The bench sweeps every depth from 2 to 7 against every legal burst length, in both directions.

In transmit it fills the FIFO burst by burst until the next burst no longer fits, then drains the FIFO one word at a time. It checks that a request reappears on exactly the edge after the count falls to depth minus burst. A gate that is off by one either overruns the FIFO or stalls one word late.

In receive it checks that no request appears before a full burst is waiting. It also checks that the count saturates at the depth on the first excess word.

Separate cases cover the rest:
- Same-edge issue and event. A design that drops one of the two updates ends on the wrong count.
- Underflow at zero.
- Each kind of invalid setting.
- Changes to the settings while enabled. A design that reads its inputs live would issue the wrong size.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_BUSY  = 2'd2,
        CH_FAULT = 2'd3
    } ch_state_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } ch_dir_e;

endpackage

// File: rtl/dcf_cfg_hold.sv
module dcf_cfg_hold
    import dcf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] fifo_in,
    input  logic [CNT_W-1:0] burst_in,
    input  logic             dir_in,
    output logic [CNT_W-1:0] fifo_q,
    output logic [CNT_W-1:0] burst_q,
    output ch_dir_e          dir_q,
    output logic             cfg_ok
);

    // Validity is judged on the live inputs: it decides the OFF exit.
    always_comb begin
        cfg_ok = (burst_in != '0) && (burst_in < fifo_in);
    end

    // Shadow copies follow the inputs only while the channel is off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q  <= '0;
            burst_q <= '0;
            dir_q   <= DIR_TX;
        end else if (load) begin
            fifo_q  <= fifo_in;
            burst_q <= burst_in;
            dir_q   <= ch_dir_e'(dir_in);
        end
    end

endmodule

// File: rtl/dcf_occupancy.sv
module dcf_occupancy
    import dcf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  ch_dir_e          dir,
    input  logic             issue,
    input  logic             evt,
    input  logic [CNT_W-1:0] burst,
    input  logic [CNT_W-1:0] fifo,
    output logic [CNT_W-1:0] count,
    output logic             credit_ok,
    output logic             err
);

    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] add_amt;
    logic [SUM_W-1:0] sub_amt;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] diff;
    logic [CNT_W-1:0] count_nxt;
    logic             underflow;
    logic             overflow;

    // Burst gate, evaluated on the registered count.
    always_comb begin
        if (dir == DIR_TX) begin
            credit_ok = ({1'b0, count} + {1'b0, burst}) <= {1'b0, fifo};
        end else begin
            credit_ok = count >= burst;
        end
    end

    // Direction decides which side adds and which side subtracts.
    always_comb begin
        if (dir == DIR_TX) begin
            add_amt = issue ? {1'b0, burst} : '0;
            sub_amt = evt   ? SUM_W'(1)     : '0;
        end else begin
            add_amt = evt   ? SUM_W'(1)     : '0;
            sub_amt = issue ? {1'b0, burst} : '0;
        end
    end

    always_comb begin
        sum       = {1'b0, count} + add_amt;
        diff      = sum - sub_amt;
        underflow = sum < sub_amt;
        overflow  = !underflow && (diff > {1'b0, fifo});
        if (underflow) begin
            count_nxt = '0;
        end else if (overflow) begin
            count_nxt = fifo;
        end else begin
            count_nxt = diff[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            err   <= 1'b0;
        end else if (clear) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            count <= count_nxt;
            if (underflow || overflow) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dcf_fsm.sv
module dcf_fsm
    import dcf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chan_en,
    input  logic      cfg_ok,
    input  logic      credit_ok,
    input  logic      burst_done,
    output ch_state_e state,
    output logic      issue,
    output logic      load_cfg,
    output logic      count_clear,
    output logic      burst_req,
    output logic      cfg_err
);

    ch_state_e state_nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions.
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_OFF: begin
                if (chan_en) begin
                    state_nxt = cfg_ok ? CH_ARMED : CH_FAULT;
                end
            end
            CH_ARMED: begin
                if (!chan_en) begin
                    state_nxt = CH_OFF;
                end else if (credit_ok) begin
                    state_nxt = CH_BUSY;
                end
            end
            CH_BUSY: begin
                if (!chan_en) begin
                    state_nxt = CH_OFF;
                end else if (burst_done) begin
                    state_nxt = CH_ARMED;
                end
            end
            CH_FAULT: begin
                if (!chan_en) begin
                    state_nxt = CH_OFF;
                end
            end
            default: state_nxt = CH_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        issue       = 1'b0;
        load_cfg    = 1'b0;
        count_clear = !chan_en;
        burst_req   = 1'b0;
        cfg_err     = 1'b0;
        unique case (state)
            CH_OFF: begin
                load_cfg    = 1'b1;
                count_clear = 1'b1;
            end
            CH_ARMED: begin
                issue = chan_en && credit_ok;
            end
            CH_BUSY: begin
                burst_req = 1'b1;
            end
            CH_FAULT: begin
                cfg_err     = 1'b1;
                count_clear = 1'b1;
            end
            default: count_clear = 1'b1;
        endcase
    end

endmodule

// File: rtl/dma_credit_flow.sv
module dma_credit_flow
    import dcf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             dir_rx,
    input  logic [CNT_W-1:0] cfg_fifo_words,
    input  logic [CNT_W-1:0] cfg_burst_words,
    input  logic             per_evt,
    input  logic             burst_done,
    output logic             burst_req,
    output logic [CNT_W-1:0] fill_level,
    output logic             cfg_err,
    output logic             cnt_err
);

    logic [CNT_W-1:0] fifo_q;
    logic [CNT_W-1:0] burst_q;
    ch_dir_e          dir_q;
    logic             cfg_ok;
    logic             credit_ok;
    logic             issue;
    logic             load_cfg;
    logic             count_clear;
    ch_state_e        state;

    dcf_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cfg),
        .fifo_in  (cfg_fifo_words),
        .burst_in (cfg_burst_words),
        .dir_in   (dir_rx),
        .fifo_q   (fifo_q),
        .burst_q  (burst_q),
        .dir_q    (dir_q),
        .cfg_ok   (cfg_ok)
    );

    dcf_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .cfg_ok      (cfg_ok),
        .credit_ok   (credit_ok),
        .burst_done  (burst_done),
        .state       (state),
        .issue       (issue),
        .load_cfg    (load_cfg),
        .count_clear (count_clear),
        .burst_req   (burst_req),
        .cfg_err     (cfg_err)
    );

    dcf_occupancy #(.CNT_W(CNT_W)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (count_clear),
        .dir       (dir_q),
        .issue     (issue),
        .evt       (per_evt),
        .burst     (burst_q),
        .fifo      (fifo_q),
        .count     (fill_level),
        .credit_ok (credit_ok),
        .err       (cnt_err)
    );

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_en,
    input logic             burst_req,
    input logic             burst_done,
    input logic [CNT_W-1:0] fill_level,
    input logic [CNT_W-1:0] fifo_q,
    input logic             cfg_err,
    input logic             cnt_err
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && !burst_done && chan_en) |=> burst_req); // R7

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (fill_level == '0 && !burst_req && !cfg_err && !cnt_err)); // R9

    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !burst_req); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_err && chan_en) |=> cnt_err); // R12

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= fifo_q); // R11

endmodule

bind dma_credit_flow dcf_checker #(.CNT_W(CNT_W)) u_dcf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .burst_req  (burst_req),
    .burst_done (burst_done),
    .fill_level (fill_level),
    .fifo_q     (fifo_q),
    .cfg_err    (cfg_err),
    .cnt_err    (cnt_err)
);

// File: tb/dma_credit_flow_bench.sv
module dma_credit_flow_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0;
    logic          dir_rx = 1'b0;
    logic [CW-1:0] cfg_fifo_words = '0;
    logic [CW-1:0] cfg_burst_words = '0;
    logic          per_evt = 1'b0;
    logic          burst_done = 1'b0;
    logic          burst_req;
    logic [CW-1:0] fill_level;
    logic          cfg_err;
    logic          cnt_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_credit_flow #(.CNT_W(CW)) u_dma_credit_flow (
        .clk             (clk),
        .rst_n           (rst_n),
        .chan_en         (chan_en),
        .dir_rx          (dir_rx),
        .cfg_fifo_words  (cfg_fifo_words),
        .cfg_burst_words (cfg_burst_words),
        .per_evt         (per_evt),
        .burst_done      (burst_done),
        .burst_req       (burst_req),
        .fill_level      (fill_level),
        .cfg_err         (cfg_err),
        .cnt_err         (cnt_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enable(int f, int b, bit rx);
        cfg_fifo_words  = CW'(f);
        cfg_burst_words = CW'(b);
        dir_rx          = rx;
        chan_en         = 1'b1;
        tick();
    endtask

    task automatic disable_and_check();
        chan_en = 1'b0;
        tick();
        check("R9 fill cleared", int'(fill_level), 0);
        check("R9 req cleared", int'(burst_req), 0);
        check("R9 cnt_err cleared", int'(cnt_err), 0);
        check("R9 cfg_err cleared", int'(cfg_err), 0);
    endtask

    task automatic tx_case(int f, int b);
        int k;
        int d;
        enable(f, b, 1'b0);
        check("R4 armed no req yet", int'(burst_req), 0);
        tick();
        check("R4 first issue req", int'(burst_req), 1);
        check("R4 first issue fill", int'(fill_level), b);
        tick();
        check("R7 req held without done", int'(burst_req), 1);
        k = 1;
        forever begin
            burst_done = 1'b1;
            tick();
            burst_done = 1'b0;
            check("R7 req drops after done", int'(burst_req), 0);
            tick();
            if ((k + 1) * b <= f) begin
                k++;
                check("R4 next burst fits req", int'(burst_req), 1);
                check("R4 next burst fill", int'(fill_level), k * b);
            end else begin
                check("R4 gate closed req", int'(burst_req), 0);
                check("R4 gate closed fill", int'(fill_level), k * b);
                break;
            end
        end
        d = k * b - (f - b);
        for (int i = 1; i <= d; i++) begin
            per_evt = 1'b1;
            tick();
            per_evt = 1'b0;
            check("R5 consume fill", int'(fill_level), k * b - i);
            check("R5 consume no req", int'(burst_req), 0);
        end
        tick();
        check("R4 reopen req", int'(burst_req), 1);
        check("R4 reopen fill", int'(fill_level), f);
        per_evt = 1'b1;
        repeat (f) tick();
        per_evt = 1'b0;
        check("R10 drained to zero", int'(fill_level), 0);
        check("R10 no error at zero", int'(cnt_err), 0);
        per_evt = 1'b1;
        tick();
        per_evt = 1'b0;
        check("R10 underflow flag", int'(cnt_err), 1);
        check("R10 underflow holds zero", int'(fill_level), 0);
        tick();
        check("R12 flag sticky", int'(cnt_err), 1);
        check("R12 burst still outstanding", int'(burst_req), 1);
        disable_and_check();
    endtask

    task automatic rx_case(int f, int b);
        enable(f, b, 1'b1);
        for (int i = 1; i <= b; i++) begin
            per_evt = 1'b1;
            tick();
            check("R6 produce fill", int'(fill_level), i);
            check("R6 no req before burst ready", int'(burst_req), 0);
        end
        per_evt = 1'b0;
        tick();
        check("R6 issue req", int'(burst_req), 1);
        check("R6 issue fill", int'(fill_level), 0);
        per_evt = 1'b1;
        repeat (f) tick();
        per_evt = 1'b0;
        check("R11 fill at depth", int'(fill_level), f);
        check("R11 no error at depth", int'(cnt_err), 0);
        per_evt = 1'b1;
        tick();
        per_evt = 1'b0;
        check("R11 overflow flag", int'(cnt_err), 1);
        check("R11 saturates at depth", int'(fill_level), f);
        burst_done = 1'b1;
        tick();
        burst_done = 1'b0;
        check("R7 rx req drops", int'(burst_req), 0);
        tick();
        check("R12 keeps issuing req", int'(burst_req), 1);
        check("R12 keeps issuing fill", int'(fill_level), f - b);
        check("R12 flag still set", int'(cnt_err), 1);
        disable_and_check();
    endtask

    task automatic bad_cfg(int f, int b);
        enable(f, b, 1'b0);
        check("R2 fault flag", int'(cfg_err), 1);
        check("R2 no req", int'(burst_req), 0);
        tick();
        tick();
        check("R2 fault held", int'(cfg_err), 1);
        check("R2 still no req", int'(burst_req), 0);
        check("R2 count idle", int'(fill_level), 0);
        disable_and_check();
    endtask

    initial begin
        repeat (3) tick();
        check("R1 reset fill", int'(fill_level), 0);
        check("R1 reset req", int'(burst_req), 0);
        check("R1 reset cfg_err", int'(cfg_err), 0);
        check("R1 reset cnt_err", int'(cnt_err), 0);
        rst_n = 1'b1;
        tick();
        check("R1 after release fill", int'(fill_level), 0);
        check("R1 after release req", int'(burst_req), 0);

        for (int f = 2; f <= 7; f++) begin
            for (int b = 1; b < f; b++) begin
                tx_case(f, b);
                rx_case(f, b);
            end
        end

        bad_cfg(4, 0);
        bad_cfg(4, 4);
        bad_cfg(4, 9);
        bad_cfg(0, 0);

        // R3: settings changed while enabled are ignored.
        enable(8, 2, 1'b0);
        cfg_burst_words = CW'(5);
        cfg_fifo_words  = CW'(3);
        dir_rx          = 1'b1;
        tick();
        check("R3 latched burst size", int'(fill_level), 2);
        check("R3 latched direction req", int'(burst_req), 1);
        disable_and_check();

        // R8: receive, issue and produce on the same edge.
        enable(8, 2, 1'b1);
        per_evt = 1'b1;
        repeat (3) tick();
        per_evt = 1'b0;
        check("R8 rx both applied fill", int'(fill_level), 1);
        check("R8 rx issue req", int'(burst_req), 1);
        disable_and_check();

        // R8: transmit, issue and consume on the same edge.
        enable(8, 4, 1'b0);
        tick();
        check("R8 tx first fill", int'(fill_level), 4);
        burst_done = 1'b1;
        tick();
        burst_done = 1'b0;
        per_evt = 1'b1;
        tick();
        per_evt = 1'b0;
        check("R8 tx both applied fill", int'(fill_level), 7);
        check("R8 tx issue req", int'(burst_req), 1);
        disable_and_check();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule